// File: doc/BRIEF.md
# Load-Multiple Word Sequencer

This block carries out a multi-cycle register load from memory. A start pulse supplies the first destination register number. It also supplies the pieces of the starting address: a base register number, that register's value, and a 16-bit signed displacement. From that point the sequencer reads one 32-bit word at a time over a request/response memory port. It puts each word, zero-extended to 64 bits, into the register file through a single write port. It then moves on to the next register and the next word address. The run stops once register 31 has been written.

The starting register number sets the length of the run. A start at register 31 moves a single word, and a start at register 0 fills the whole file. Only one memory read is in flight at any time. A start pulse that arrives while a run is active is dropped. A one-cycle completion pulse follows the final register write.

Top module: `lmw_seq`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and rf_we_o are all low.
- R2: A start_i pulse seen while idle is taken at that clock edge. From the next cycle busy_o is high, mem_req_o is high, and the request addresses the starting effective address for register start_rt_i.
- R3: The starting effective address is the displacement disp_i, sign-extended to ADDR_W bits, plus base_val_i. When base_reg_i equals 0, zero is used in place of base_val_i. The sum wraps modulo 2^ADDR_W.
- R4: A request is taken on a clock edge where mem_req_o and mem_gnt_i are both high. After that, mem_req_o stays low until the matching mem_rvalid_i has been seen, so at most one read is outstanding.
- R5: In a cycle where the sequencer waits for data and mem_rvalid_i is high, rf_we_o is high in that same cycle. rf_waddr_o holds the current register. rf_wdata_o holds mem_rdata_i in bits 31:0 and zeros in bits 63:32.
- R6: After each write below register 31, the next request targets register number plus 1 at address plus 4, wrapping modulo 2^ADDR_W.
- R7: A run starting at register n performs exactly 32-n writes, to registers n through 31 in increasing order. Start 31 gives one write and start 0 gives 32 writes.
- R8: done_o is high for exactly one cycle, the cycle after the write to register 31. busy_o stays high from the cycle after start until that done cycle, inclusive.
- R9: start_i is ignored while busy_o is high. The register sequence, the addresses and the write count of the active run are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| start_rt_i | input | REG_W | First destination register |
| base_reg_i | input | REG_W | Base register number (0 selects a zero base) |
| base_val_i | input | ADDR_W | Value of the base register |
| disp_i | input | 16 | Signed displacement |
| busy_o | output | 1 | Run in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_gnt_i | input | 1 | Memory takes the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | WORD_W | Read data word |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | REG_W | Register write index |
| rf_wdata_o | output | XLEN | Zero-extended write data |

## Verification
The bench builds the block with ADDR_W set to 20 and leaves the other parameters at their defaults. A 20-bit address is wider than the displacement, so a negative displacement visibly sign-extends into the upper address bits. It is also narrow enough that a base near 0xFFFF0 wraps to zero partway through a run. The default 5-bit register index brings both edge lengths into reach: a single write from register 31 and a full 32-write run from register 0. Grant and response latencies vary from cycle to cycle, which exercises back-to-back beats as well as long waits.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  localparam int unsigned DISP_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lmw_state_e;
endpackage

// File: rtl/lmw_ea_calc.sv
module lmw_ea_calc #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DISP_W = 16
) (
  input  logic [REG_W-1:0]  base_reg_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] disp_ext;

  // register 0 as base means literal zero
  assign base_sel = (base_reg_i == '0) ? '0 : base_val_i;
  assign disp_ext = ADDR_W'($signed(disp_i));
  assign ea_o     = base_sel + disp_ext;
endmodule

// File: rtl/lmw_zext.sv
module lmw_zext #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned XLEN   = 64
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [XLEN-1:0]   data_o
);
  generate
    if (XLEN > WORD_W) begin : g_pad
      assign data_o = {{(XLEN-WORD_W){1'b0}}, word_i};
    end else begin : g_trunc
      assign data_o = word_i[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/lmw_fsm.sv
module lmw_fsm
  import lmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  start_rt_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [REG_W-1:0]  LAST_REG = '1;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_W / 8);

  lmw_state_e        state_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      reg_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_REQ;
          reg_q   <= start_rt_i;
          addr_q  <= ea_i;
        end
        ST_REQ: if (mem_gnt_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (reg_q == LAST_REG) begin
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_REQ;
            reg_q   <= reg_q + 1'b1;
            addr_q  <= addr_q + STEP;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = addr_q;
  assign rf_we_o    = (state_q == ST_WAIT) && mem_rvalid_i;
  assign rf_waddr_o = reg_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  assert_start_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (mem_req_o && rf_waddr_o == $past(start_rt_i)));

  assert_single_outstanding_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  assert_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o != LAST_REG) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + STEP
                 && rf_waddr_o == $past(rf_waddr_o) + 1'b1));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && rf_waddr_o == LAST_REG) |=> done_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !rf_we_o) |=> $stable(rf_waddr_o) && $stable(mem_addr_o));
endmodule

// File: rtl/lmw_seq.sv
module lmw_seq
  import lmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned XLEN   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [REG_W-1:0]  start_rt_i,
  input  logic [REG_W-1:0]  base_reg_i,
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o
);
  logic [ADDR_W-1:0] ea;

  lmw_ea_calc #(.ADDR_W(ADDR_W), .REG_W(REG_W), .DISP_W(DISP_W)) u_ea (
    .base_reg_i (base_reg_i),
    .base_val_i (base_val_i),
    .disp_i     (disp_i),
    .ea_o       (ea)
  );

  lmw_fsm #(.ADDR_W(ADDR_W), .REG_W(REG_W), .WORD_W(WORD_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_rt_i   (start_rt_i),
    .ea_i         (ea),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .rf_we_o      (rf_we_o),
    .rf_waddr_o   (rf_waddr_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  lmw_zext #(.WORD_W(WORD_W), .XLEN(XLEN)) u_zext (
    .word_i (mem_rdata_i),
    .data_o (rf_wdata_o)
  );

  assert_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (rf_wdata_o[XLEN-1:WORD_W] == '0));

  assert_we_needs_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (busy_o && !mem_req_o));
endmodule

// File: tb/lmw_seq_tb.sv
module lmw_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [4:0]    start_rt_i = '0;
  logic [4:0]    base_reg_i = '0;
  logic [AW-1:0] base_val_i = '0;
  logic [15:0]   disp_i = '0;
  logic          busy_o, done_o, mem_req_o, rf_we_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_gnt_i = 1'b0;
  logic          mem_rvalid_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic [4:0]    rf_waddr_o;
  logic [63:0]   rf_wdata_o;

  lmw_seq #(.ADDR_W(AW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memfn(input logic [AW-1:0] a);
    return {a[15:0] * 16'd3 + 16'h1357, a[19:4] ^ 16'hc0de};
  endfunction

  // reference model state
  bit            m_active = 0;
  bit            m_done_now = 0;
  int            m_reg = 0;
  logic [AW-1:0] m_addr = '0;
  int            m_writes = 0;
  bit            pend = 0;
  int            lat = 0;
  logic [AW-1:0] pend_addr = '0;
  logic [15:0]   lfsr = 16'hace1;

  function automatic logic [AW-1:0] ref_ea(input logic [4:0] br, input logic [AW-1:0] bv,
                                           input logic [15:0] d);
    logic [AW-1:0] b;
    logic [AW-1:0] dx;
    b  = (br == 0) ? '0 : bv;
    dx = {{(AW-16){d[15]}}, d};
    return b + dx;
  endfunction

  // memory responder: drives shortly after each rising edge
  always @(posedge clk_i) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_ni) begin
      mem_gnt_i = 0; mem_rvalid_i = 0;
    end else begin
      mem_gnt_i = lfsr[0] | lfsr[3];
      if (pend && lat == 0) begin
        mem_rvalid_i = 1; mem_rdata_i = memfn(pend_addr); pend = 0;
      end else begin
        mem_rvalid_i = 0; mem_rdata_i = lfsr * 16'd7;
        if (pend) lat--;
      end
    end
  end

  // reference comparison on every clock
  always @(negedge clk_i) begin
    bit done_next;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
    if (rst_ni) begin
      done_next = 0;
      chk(done_o == m_done_now, "R8 done", done_o, m_done_now);
      chk(busy_o == (m_active || m_done_now), "R8 busy", busy_o, m_active || m_done_now);
      if (mem_req_o) chk(m_active && !pend, "R4 request outstanding/idle", pend, 0);
      if (start_i && !(m_active || m_done_now)) begin
        m_active = 1; m_reg = start_rt_i; m_writes = 0;
        m_addr = ref_ea(base_reg_i, base_val_i, disp_i);
      end else if (mem_req_o && mem_gnt_i) begin
        chk(mem_addr_o == m_addr, "R3 R6 request address", mem_addr_o, m_addr);
        pend = 1; lat = int'(lfsr[2:1]); pend_addr = mem_addr_o;
      end
      if (rf_we_o) begin
        chk(m_active, "R5 write while idle", 1, 0);
        chk(rf_waddr_o == 5'(m_reg), "R7 write register", rf_waddr_o, m_reg);
        chk(rf_wdata_o == {32'h0, memfn(m_addr)}, "R5 write data", rf_wdata_o, {32'h0, memfn(m_addr)});
        m_writes++;
        if (m_reg == 31) begin
          m_active = 0; done_next = 1;
        end else begin
          m_reg++; m_addr = m_addr + AW'(4);
        end
      end
      m_done_now = done_next;
    end
  end

  task automatic run_op(input int rt, input int br, input logic [AW-1:0] bv,
                        input logic [15:0] d, input bit poke);
    int n;
    @(posedge clk_i); #2;
    start_i = 1; start_rt_i = 5'(rt); base_reg_i = 5'(br); base_val_i = bv; disp_i = d;
    @(posedge clk_i); #2;
    start_i = 0;
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
      if (poke && n == 6) begin
        #1; start_i = 1; start_rt_i = 5'd3; base_val_i = '1; disp_i = 16'h0040;
        @(posedge clk_i); #2; start_i = 0;
      end
    end
    @(posedge clk_i); #3;
    chk(m_writes == 32 - rt, poke ? "R9 write count after busy start" : "R7 write count",
        m_writes, 32 - rt);
    @(posedge clk_i); #3;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R1 reset outputs",
        {busy_o, done_o, mem_req_o, rf_we_o}, 0);
    rst_ni = 1;
    // R2: start idle fields go straight to first request
    @(posedge clk_i); #2;
    start_i = 1; start_rt_i = 5'd29; base_reg_i = 5'd4; base_val_i = 20'h01230; disp_i = 16'h0010;
    @(posedge clk_i); #2;
    start_i = 0;
    @(negedge clk_i);
    chk(busy_o && mem_req_o && rf_waddr_o == 5'd29, "R2 start taken", {busy_o, mem_req_o}, 3);
    chk(mem_addr_o == 20'h01240, "R2 first address", mem_addr_o, 20'h01240);
    while (!done_o) @(negedge clk_i);
    repeat (2) @(posedge clk_i);
    run_op(31, 7, 20'h00400, 16'h0000, 0);   // R7 single transfer
    run_op(0, 2, 20'h08000, 16'h0100, 0);    // R7 full register file
    run_op(20, 9, 20'h00100, 16'hfff8, 0);   // R3 negative displacement
    run_op(28, 0, 20'h55550, 16'h0020, 0);   // R3 base register 0 gives zero base
    run_op(26, 3, 20'hffff0, 16'h0000, 0);   // R6 address wrap
    run_op(10, 5, 20'h02000, 16'h7ffc, 1);   // R9 start while busy
    chk(!busy_o && !done_o, "R8 idle after run", busy_o, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule